// File: doc/BRIEF.md
# Direct-Mapped Second-Level Cache Controller

This block sits between a processor-side request port and a main-memory port. It holds a small direct-mapped cache of 16-byte lines, 4 words of 32 bits each, with an 8-bit tag per line. The cacheable window is therefore 256 times the cache capacity. Each processor request is a single 32-bit word read or write. Line refills and victim write-backs go to memory as 4-beat bursts. Single-word transfers serve write-through forwarding, non-allocating write misses and uncacheable accesses.

Two configuration inputs control the write behaviour and are held steady while the controller is idle between requests.

- A 2-bit policy input selects one of three write policies:
  - write-through;
  - write-back with a true per-line dirty flag;
  - write-back that treats every valid line as modified.
- A borrow input reuses the top tag bit as the dirty flag instead of a separate dirty store. In this mode only the low 7 tag bits are compared, and the upper half of the former cacheable window becomes uncacheable.

Write-back of a victim happens only when its line is about to be replaced. The read that caused the miss waits until the victim has been stored and the new line fetched.

Top module: `dm_l2_cache`

## Requirements
- R1: After reset every line is invalid and clean, `cpuReqReady` is 1, and neither `cpuRespValid` nor `memReqValid` is asserted; the first read of any cacheable address is a miss.
- R2: A read hit returns the cached word with no memory transfer; every request gets exactly one single-cycle `cpuRespValid` pulse.
- R3: A read miss fetches the whole line as 4 memory reads starting at the line base (address bits [3:0] zero), beats in word order 0..3, installs it, then returns the requested word.
- R4: In either write-back policy (`cfgPolicy` 2'b01 or 2'b10), a write hit updates only the cached word; no memory write is made and a later read returns the new value.
- R5: With `cfgPolicy`=2'b01, a read miss whose victim line is valid and dirty first writes the 4 victim words to the victim's line address, then refills; a clean victim is not written back.
- R6: With `cfgPolicy`=2'b10, a read miss that replaces any valid line writes back its 4 words before the refill, even if the line was never written.
- R7: With `cfgPolicy`=2'b00 (2'b11 behaves the same), a write hit updates the cached word and makes exactly one memory write, and a replaced line is never written back.
- R8: A write miss in any policy makes one memory write and allocates no line, so a following read of that address is a miss.
- R9: An address is uncacheable when bit 15 is 1, or when `cfgBorrow`=1 and bit 14 is 1; such a request makes exactly one memory transfer of its own kind and changes no line state.
- R10: With `cfgBorrow`=1, dirty tracking under `cfgPolicy`=2'b01 and forced write-back under 2'b10 behave as in R5 and R6, while only tag bits [13:7] are compared.
- R11: Once `memReqValid` is raised, it and `memReqAddr` and `memReqWrite` hold steady until `memReqReady` accepts the beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPolicy | input | 2 | Write policy: 00 write-through, 01 write-back with dirty flag, 10 write-back always dirty, 11 as 00 |
| cfgBorrow | input | 1 | Store dirty flag in the top tag bit, halving the cacheable window |
| cpuReqValid | input | 1 | Processor request valid |
| cpuReqReady | output | 1 | Controller can accept a request |
| cpuReqWrite | input | 1 | 1 for a write request |
| cpuReqAddr | input | 16 | Byte address of the word |
| cpuReqWdata | input | 32 | Write data |
| cpuRespValid | output | 1 | One-cycle completion pulse |
| cpuRespRdata | output | 32 | Read data, valid with `cpuRespValid` on reads |
| memReqValid | output | 1 | Memory beat valid |
| memReqReady | input | 1 | Memory accepts the beat |
| memReqWrite | output | 1 | 1 for a write beat |
| memReqLast | output | 1 | Final beat of a burst or a single transfer |
| memReqAddr | output | 16 | Byte address of the beat |
| memReqWdata | output | 32 | Write data of the beat |
| memRdata | input | 32 | Read data, taken in the cycle a read beat is accepted |

## Verification
Directed sequences run each policy through four steps on one index:
- a cold read miss;
- a repeated read;
- a write hit;
- a conflicting read.

These steps separate policies by the number of write beats seen before the refill: zero for write-through, four only after a write in the dirty-tracking mode, and four on every replacement in the always-dirty mode. Uncacheable reads that share an index with a resident line show whether a bypass disturbs line state. In borrow mode, addresses with tag bit 7 set show whether the halved window is enforced. Long random mixes then draw from a small tag set, so hits, conflicts, write misses and bypasses interleave under a memory that stalls at random. Any lost, misplaced or skipped write-back appears later as wrong read data against an architectural golden copy.

// File: rtl/l2_pkg.sv
package l2_pkg;

  localparam logic [1:0] POL_WT        = 2'b00;
  localparam logic [1:0] POL_WB_DIRTY  = 2'b01;
  localparam logic [1:0] POL_WB_ALWAYS = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_REFILL,
    ST_RESPOND,
    ST_BYPASS
  } ctrlState_e;

  typedef enum logic [1:0] {
    MSEL_REQ,
    MSEL_VICTIM,
    MSEL_FILL
  } memSel_e;

  typedef struct packed {
    logic    capture;
    logic    wordWr;
    logic    fillWr;
    logic    install;
    logic    markDirty;
    logic    grabMem;
    memSel_e memSel;
  } dpCtrl_t;

endpackage

// File: rtl/l2_ctrl.sv
module l2_ctrl
  import l2_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgPolicy,
  input  logic              cpuReqValid,
  output logic              cpuReqReady,
  output logic              cpuRespValid,
  input  logic              reqWrite,
  input  logic              cacheable,
  input  logic              hit,
  input  logic              victimValid,
  input  logic              victimDirty,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic              memReqLast,
  output dpCtrl_t           dp,
  output logic [WORD_W-1:0] beat
);

  localparam logic [WORD_W-1:0] BEAT_MAX = WORD_W'(WORDS - 1);

  ctrlState_e        state, nextState;
  logic [WORD_W-1:0] beatCnt;
  logic              memFire;
  logic              lastBeat;
  logic              isWriteThrough;
  logic              needWriteBack;

  assign beat           = beatCnt;
  assign memFire        = memReqValid && memReqReady;
  assign isWriteThrough = (cfgPolicy != POL_WB_DIRTY) && (cfgPolicy != POL_WB_ALWAYS);
  assign needWriteBack  = victimValid &&
                          ((cfgPolicy == POL_WB_ALWAYS) ||
                           ((cfgPolicy == POL_WB_DIRTY) && victimDirty));
  assign lastBeat       = (state == ST_BYPASS) || (beatCnt == BEAT_MAX);
  assign memReqLast     = memReqValid && lastBeat;

  always_comb begin
    nextState    = state;
    dp           = '0;
    dp.memSel    = MSEL_REQ;
    cpuReqReady  = 1'b0;
    cpuRespValid = 1'b0;
    memReqValid  = 1'b0;
    memReqWrite  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpuReqReady = 1'b1;
        if (cpuReqValid) begin
          dp.capture = 1'b1;
          nextState  = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (!cacheable) begin
          nextState = ST_BYPASS;
        end else if (reqWrite) begin
          if (hit) begin
            dp.wordWr    = 1'b1;
            dp.markDirty = (cfgPolicy == POL_WB_DIRTY);
            nextState    = isWriteThrough ? ST_BYPASS : ST_RESPOND;
          end else begin
            nextState = ST_BYPASS;
          end
        end else if (hit) begin
          nextState = ST_RESPOND;
        end else begin
          nextState = needWriteBack ? ST_WRITEBACK : ST_REFILL;
        end
      end
      ST_WRITEBACK: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        dp.memSel   = MSEL_VICTIM;
        if (memFire && lastBeat) nextState = ST_REFILL;
      end
      ST_REFILL: begin
        memReqValid = 1'b1;
        dp.memSel   = MSEL_FILL;
        dp.fillWr   = memFire;
        if (memFire && lastBeat) begin
          dp.install = 1'b1;
          nextState  = ST_RESPOND;
        end
      end
      ST_BYPASS: begin
        memReqValid = 1'b1;
        memReqWrite = reqWrite;
        dp.memSel   = MSEL_REQ;
        dp.grabMem  = memFire && !reqWrite;
        if (memFire) nextState = ST_RESPOND;
      end
      ST_RESPOND: begin
        cpuRespValid = 1'b1;
        nextState    = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
    end else begin
      state <= nextState;
      if (memFire) beatCnt <= lastBeat ? '0 : beatCnt + WORD_W'(1);
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqWrite) && $stable(beatCnt))) // R11
    else $error("memory beat dropped before acceptance");

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuRespValid |=> (!cpuRespValid && cpuReqReady)) // R2
    else $error("response longer than one cycle");

  AST_SKIP_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOOKUP && cacheable && !reqWrite && !hit &&
     cfgPolicy == POL_WB_DIRTY && !victimDirty) |=> (state == ST_REFILL)) // R5
    else $error("clean victim written back");

  AST_ALWAYS_WB: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOOKUP && cacheable && !reqWrite && !hit &&
     cfgPolicy == POL_WB_ALWAYS && victimValid) |=> (state == ST_WRITEBACK)) // R6
    else $error("valid victim not written back");

  AST_WT_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRITEBACK) |-> (cfgPolicy == POL_WB_DIRTY || cfgPolicy == POL_WB_ALWAYS)) // R7
    else $error("write-back burst in write-through policy");

endmodule

// File: rtl/l2_datapath.sv
module l2_datapath
  import l2_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 8,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgBorrow,
  input  dpCtrl_t           dp,
  input  logic [WORD_W-1:0] beat,
  input  logic              cpuReqWrite,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [DATA_W-1:0] cpuReqWdata,
  output logic [DATA_W-1:0] cpuRespRdata,
  output logic              reqWrite,
  output logic              cacheable,
  output logic              hit,
  output logic              victimValid,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata,
  input  logic [DATA_W-1:0] memRdata
);

  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int OFF_W   = BYTE_W + WORD_W;
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_LSB = OFF_W + IDX_W;
  localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [DATA_W-1:0] respReg;
  logic              respFromMem;

  logic [LINES-1:0]  validArr;
  logic [LINES-1:0]  dirtyArr;
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES][WORDS];

  logic [IDX_W-1:0]  reqIdx;
  logic [WORD_W-1:0] reqWord;
  logic [TAG_W-1:0]  reqTag;
  logic [TAG_W-1:0]  storedTag;
  logic [TAG_W-1:0]  victimTag;
  logic              upperZero;
  logic              tagMatch;

  assign reqIdx    = reqAddr[TAG_LSB-1:OFF_W];
  assign reqWord   = reqAddr[OFF_W-1:BYTE_W];
  assign reqTag    = reqAddr[TAG_MSB:TAG_LSB];
  assign storedTag = tagArr[reqIdx];
  assign reqWrite  = 1'b0 ^ reqWriteQ;

  logic reqWriteQ;

  generate
    if (ADDR_W > TAG_MSB + 1) begin : g_upper
      assign upperZero = ~|reqAddr[ADDR_W-1:TAG_MSB+1];
    end else begin : g_noUpper
      assign upperZero = 1'b1;
    end
  endgenerate

  assign cacheable   = upperZero && !(cfgBorrow && reqTag[TAG_W-1]);
  assign tagMatch    = cfgBorrow ? (storedTag[TAG_W-2:0] == reqTag[TAG_W-2:0])
                                 : (storedTag == reqTag);
  assign hit         = cacheable && validArr[reqIdx] && tagMatch;
  assign victimValid = validArr[reqIdx];
  assign victimDirty = cfgBorrow ? storedTag[TAG_W-1] : dirtyArr[reqIdx];
  assign victimTag   = cfgBorrow ? {1'b0, storedTag[TAG_W-2:0]} : storedTag;

  always_comb begin
    memReqAddr = '0;
    unique case (dp.memSel)
      MSEL_VICTIM: begin
        memReqAddr[TAG_MSB:TAG_LSB]  = victimTag;
        memReqAddr[TAG_LSB-1:OFF_W]  = reqIdx;
        memReqAddr[OFF_W-1:BYTE_W]   = beat;
      end
      MSEL_FILL: begin
        memReqAddr[TAG_MSB:TAG_LSB]  = reqTag;
        memReqAddr[TAG_LSB-1:OFF_W]  = reqIdx;
        memReqAddr[OFF_W-1:BYTE_W]   = beat;
      end
      default: memReqAddr = reqAddr;
    endcase
  end

  assign memReqWdata  = (dp.memSel == MSEL_VICTIM) ? dataArr[reqIdx][beat] : reqWdata;
  assign cpuRespRdata = respFromMem ? respReg : dataArr[reqIdx][reqWord];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr     <= '0;
      reqWdata    <= '0;
      reqWriteQ   <= 1'b0;
      respReg     <= '0;
      respFromMem <= 1'b0;
    end else begin
      if (dp.capture) begin
        reqAddr     <= cpuReqAddr;
        reqWdata    <= cpuReqWdata;
        reqWriteQ   <= cpuReqWrite;
        respFromMem <= 1'b0;
      end
      if (dp.grabMem) begin
        respReg     <= memRdata;
        respFromMem <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
      for (int i = 0; i < LINES; i++) tagArr[i] <= '0;
    end else begin
      if (dp.install) begin
        validArr[reqIdx] <= 1'b1;
        dirtyArr[reqIdx] <= 1'b0;
        tagArr[reqIdx]   <= cfgBorrow ? {1'b0, reqTag[TAG_W-2:0]} : reqTag;
      end
      if (dp.markDirty) begin
        if (cfgBorrow) tagArr[reqIdx][TAG_W-1] <= 1'b1;
        else           dirtyArr[reqIdx]        <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dp.wordWr) dataArr[reqIdx][reqWord] <= reqWdata;
    if (dp.fillWr) dataArr[reqIdx][beat]    <= memRdata;
  end

  AST_INSTALL_CACHEABLE: assert property (@(posedge clk) disable iff (!rstN)
    dp.install |-> cacheable) // R9
    else $error("uncacheable address installed");

  AST_INSTALL_ON_FILL: assert property (@(posedge clk) disable iff (!rstN)
    dp.install |-> (dp.fillWr && beat == WORD_W'(WORDS - 1))) // R3
    else $error("line installed before final refill beat");

  AST_HIT_STABLE_TAG: assert property (@(posedge clk) disable iff (!rstN)
    dp.wordWr |-> hit) // R4
    else $error("word written without a hit");

endmodule

// File: rtl/dm_l2_cache.sv
module dm_l2_cache
  import l2_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgPolicy,
  input  logic              cfgBorrow,
  input  logic              cpuReqValid,
  output logic              cpuReqReady,
  input  logic              cpuReqWrite,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [DATA_W-1:0] cpuReqWdata,
  output logic              cpuRespValid,
  output logic [DATA_W-1:0] cpuRespRdata,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic              memReqLast,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata,
  input  logic [DATA_W-1:0] memRdata
);

  localparam int WORD_W = $clog2(WORDS);

  dpCtrl_t           dp;
  logic [WORD_W-1:0] beat;
  logic              reqWrite;
  logic              cacheable;
  logic              hit;
  logic              victimValid;
  logic              victimDirty;

  l2_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgPolicy    (cfgPolicy),
    .cpuReqValid  (cpuReqValid),
    .cpuReqReady  (cpuReqReady),
    .cpuRespValid (cpuRespValid),
    .reqWrite     (reqWrite),
    .cacheable    (cacheable),
    .hit          (hit),
    .victimValid  (victimValid),
    .victimDirty  (victimDirty),
    .memReqValid  (memReqValid),
    .memReqReady  (memReqReady),
    .memReqWrite  (memReqWrite),
    .memReqLast   (memReqLast),
    .dp           (dp),
    .beat         (beat)
  );

  l2_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES),
    .WORDS  (WORDS),
    .TAG_W  (TAG_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cfgBorrow    (cfgBorrow),
    .dp           (dp),
    .beat         (beat),
    .cpuReqWrite  (cpuReqWrite),
    .cpuReqAddr   (cpuReqAddr),
    .cpuReqWdata  (cpuReqWdata),
    .cpuRespRdata (cpuRespRdata),
    .reqWrite     (reqWrite),
    .cacheable    (cacheable),
    .hit          (hit),
    .victimValid  (victimValid),
    .victimDirty  (victimDirty),
    .memReqAddr   (memReqAddr),
    .memReqWdata  (memReqWdata),
    .memRdata     (memRdata)
  );

endmodule

// File: tb/sim_dm_l2_cache.sv
module sim_dm_l2_cache;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgPolicy = 2'b00;
  logic        cfgBorrow = 1'b0;
  logic        cpuReqValid = 1'b0;
  logic        cpuReqReady;
  logic        cpuReqWrite = 1'b0;
  logic [15:0] cpuReqAddr = '0;
  logic [31:0] cpuReqWdata = '0;
  logic        cpuRespValid;
  logic [31:0] cpuRespRdata;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic        memReqWrite;
  logic        memReqLast;
  logic [15:0] memReqAddr;
  logic [31:0] memReqWdata;
  logic [31:0] memRdata = '0;

  always #2.5 clk = ~clk;

  dm_l2_cache u0 (
    .clk(clk), .rstN(rstN), .cfgPolicy(cfgPolicy), .cfgBorrow(cfgBorrow),
    .cpuReqValid(cpuReqValid), .cpuReqReady(cpuReqReady), .cpuReqWrite(cpuReqWrite),
    .cpuReqAddr(cpuReqAddr), .cpuReqWdata(cpuReqWdata), .cpuRespValid(cpuRespValid),
    .cpuRespRdata(cpuRespRdata), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqLast(memReqLast), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memRdata(memRdata)
  );

  int nChecks = 0;
  int nFail   = 0;

  logic [31:0] memArr  [int];
  logic [31:0] goldArr [int];

  function automatic logic [31:0] seedWord(int a);
    return a * 32'h9E3779B1 + 32'h1234;
  endfunction

  function automatic logic [31:0] memRead(int a);
    if (memArr.exists(a)) return memArr[a];
    return seedWord(a);
  endfunction

  function automatic logic [31:0] goldRead(int a);
    if (goldArr.exists(a)) return goldArr[a];
    return seedWord(a);
  endfunction

  int          nWr, nRd, holdErr;
  bit          orderBad;
  logic [15:0] firstWrAddr, firstRdAddr;
  bit          pendPrev = 0;
  logic [15:0] prevAddr;
  logic        prevWrite;

  always @(negedge clk) begin
    memReqReady <= ($urandom % 4) != 0;
    memRdata    <= memRead(int'(memReqAddr >> 2));
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (pendPrev && (!memReqValid || memReqAddr != prevAddr || memReqWrite != prevWrite))
        holdErr++;
      pendPrev  = memReqValid && !memReqReady;
      prevAddr  = memReqAddr;
      prevWrite = memReqWrite;
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          memArr[int'(memReqAddr >> 2)] = memReqWdata;
          if (nWr == 0) firstWrAddr = memReqAddr;
          if (nRd > 0) orderBad = 1;
          nWr++;
        end else begin
          if (nRd == 0) firstRdAddr = memReqAddr;
          nRd++;
        end
      end
    end
  end

  bit          mValid [8];
  logic [7:0]  mTag   [8];
  bit          mDirty [8];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  task automatic doReq(bit wr, logic [15:0] addr, logic [31:0] wd, string lblIn);
    bit cach, hitM, isWT;
    int idx, expWr, expRd;
    logic [7:0]  tg;
    logic [15:0] expWrBase, expRdBase;
    logic [31:0] expData, got;
    string lbl;
    isWT = (cfgPolicy == 2'b00) || (cfgPolicy == 2'b11);
    cach = !addr[15] && !(cfgBorrow && addr[14]);
    idx  = int'(addr[6:4]);
    tg   = addr[14:7];
    hitM = cach && mValid[idx] && (mTag[idx] == tg);
    expWr = 0; expRd = 0; expWrBase = '0; expRdBase = '0; expData = '0;
    if (!cach) begin
      lbl = "R9";
      if (wr) expWr = 1; else expRd = 1;
    end else if (wr) begin
      if (hitM) begin
        lbl = isWT ? "R7" : "R4";
        if (isWT) expWr = 1;
        if (cfgPolicy == 2'b01) mDirty[idx] = 1;
      end else begin
        lbl = "R8";
        expWr = 1;
      end
    end else if (hitM) begin
      lbl = "R2";
    end else begin
      lbl = "R3";
      if (mValid[idx] && (cfgPolicy == 2'b10 || (cfgPolicy == 2'b01 && mDirty[idx]))) begin
        expWr = 4;
        expWrBase = {1'b0, mTag[idx], addr[6:4], 4'h0};
        lbl = (cfgPolicy == 2'b10) ? "R6" : "R5";
      end else if (mValid[idx]) begin
        lbl = isWT ? "R7" : (cfgPolicy == 2'b01 ? "R5" : "R3");
      end
      expRd = 4;
      expRdBase = {addr[15:4], 4'h0};
      mValid[idx] = 1; mTag[idx] = tg; mDirty[idx] = 0;
    end
    if (wr) goldArr[int'(addr >> 2)] = wd;
    else    expData = goldRead(int'(addr >> 2));
    if (lblIn != "") lbl = lblIn;

    nWr = 0; nRd = 0; orderBad = 0;
    cpuReqValid = 1; cpuReqWrite = wr; cpuReqAddr = addr; cpuReqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    cpuReqValid = 0;
    while (!cpuRespValid) @(negedge clk);
    got = cpuRespRdata;
    @(negedge clk);
    if (!wr) chk({lbl, " read data"}, got, expData);
    chk({lbl, " write beats"}, 32'(nWr), 32'(expWr));
    chk({lbl, " read beats"}, 32'(nRd), 32'(expRd));
    if (expWr == 4) begin
      chk({lbl, " victim base"}, {16'h0, firstWrAddr}, {16'h0, expWrBase});
      if (expRd > 0) chk({lbl, " write-back before refill"}, 32'(orderBad), 32'd0);
    end
    if (expRd == 4) chk({lbl, " refill base R3"}, {16'h0, firstRdAddr}, {16'h0, expRdBase});
  endtask

  task automatic flushAll();
    for (int i = 0; i < 8; i++) doReq(0, {1'b0, 8'h7F, 3'(i), 4'h0}, '0, "");
  endtask

  task automatic randomPhase(int n);
    for (int k = 0; k < n; k++) begin
      logic [15:0] a;
      logic [7:0]  tg;
      tg = 8'($urandom % 6);
      if (($urandom % 10) == 0) tg[7] = 1'b1;
      a = {1'b0, tg, 3'($urandom % 8), 2'($urandom % 4), 2'b00};
      if (($urandom % 16) == 0) a[15] = 1'b1;
      doReq(bit'($urandom % 2), a, $urandom, "");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin mValid[i] = 0; mTag[i] = '0; mDirty[i] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", 32'(cpuReqReady), 32'd1);
    chk("R1 no response after reset", 32'(cpuRespValid), 32'd0);
    chk("R1 no memory request after reset", 32'(memReqValid), 32'd0);

    // write-through directed
    cfgPolicy = 2'b00;
    doReq(0, 16'h0120, '0, "R1");               // cold miss
    doReq(0, 16'h0124, '0, "R2");               // hit
    doReq(1, 16'h0128, 32'hA5A5_0001, "R7");    // WT write hit
    doReq(1, 16'h0A40, 32'h0000_BEEF, "R8");    // write miss
    doReq(0, 16'h0A40, '0, "R8");               // must miss
    doReq(0, 16'h0920, '0, "R7");               // conflict, no write-back
    doReq(0, 16'h8120, '0, "R9");               // uncacheable same index
    doReq(0, 16'h0924, '0, "R9");               // still hit
    randomPhase(250);
    flushAll();

    // write-back with dirty flag
    cfgPolicy = 2'b01;
    doReq(0, 16'h0230, '0, "R3");
    doReq(1, 16'h0234, 32'h1111_2222, "R4");
    doReq(0, 16'h0234, '0, "R4");
    doReq(0, 16'h0B30, '0, "R5");               // dirty victim
    doReq(0, 16'h0230, '0, "R5");               // clean victim
    randomPhase(250);
    flushAll();

    // write-back always dirty
    cfgPolicy = 2'b10;
    doReq(0, 16'h0350, '0, "R6");
    doReq(0, 16'h0C50, '0, "R6");               // never written, still written back
    doReq(1, 16'h0C54, 32'h3333_4444, "R4");
    randomPhase(250);
    flushAll();

    // policy 11 behaves as write-through
    cfgPolicy = 2'b11;
    doReq(0, 16'h0460, '0, "R7");
    doReq(1, 16'h0464, 32'h5555_6666, "R7");
    doReq(0, 16'h0D60, '0, "R7");
    randomPhase(150);
    flushAll();

    // borrowed dirty bit
    cfgBorrow = 1'b1;
    cfgPolicy = 2'b01;
    doReq(0, 16'h4070, '0, "R10");              // tag bit 7 set: uncacheable
    doReq(1, 16'h4074, 32'h7777_0000, "R10");
    doReq(0, 16'h0070, '0, "R10");
    doReq(1, 16'h0074, 32'h7777_8888, "R10");
    doReq(0, 16'h0170, '0, "R10");              // dirty victim held in tag bit
    doReq(0, 16'h0070, '0, "R10");              // clean victim skipped
    randomPhase(250);
    flushAll();
    cfgPolicy = 2'b10;
    doReq(0, 16'h0170, '0, "R10");
    randomPhase(200);
    flushAll();

    // R11 hold-until-accepted
    chk("R11 memory request stability violations", 32'(holdErr), 32'd0);
    summary();
    $finish;
  end

endmodule